// File: doc/BRIEF.md
# Coherent Chirp Symbol Demodulator

This block recovers binary data from a chirp-keyed baseband stream. A zero is sent as a chirp whose frequency rises across the bit, and a one as a chirp whose frequency falls. The block takes one unsigned 8-bit ADC word on every clock cycle. It also takes a square wave from an external bit-clock recovery loop, whose rising edges mark symbol boundaries.

Each sample is first re-centred around zero. It is then multiplied by the matching entry of two locally computed reference chirps, one for each bit value. The two products run into two signed accumulators. At the next symbol boundary, the block compares the two sums, registers the decided bit and raises a one-cycle valid strobe. In the same cycle it starts the next symbol's accumulation.

Top module: `chirp_corr_demod`

## Requirements
- R1: While `rst_i` is high and after its release, `bit_vld_o` is 0 and `bit_o` is 0. No symbol is accumulated until the first symbol boundary.
- R2: `bsync_i` passes through two synchronizing flops and an edge register. When `bsync_i` goes high before rising clock edge P, the sample present at edge P+2 is index 0 of the new symbol. The sample at edge P+2+k is index k.
- R3: Each ADC word is turned into signed form by subtracting 128 before it is multiplied.
- R4: The reference for index j (0..63) is tri(p), with tri(p) = p-64 for p<128 and 191-p otherwise. The phase p is (2j + floor(j*j/32)) mod 256 for the zero path and (6j - floor(j*j/32)) mod 256 for the one path.
- R5: Each path sums (sample-128)*reference over the indices of one symbol. The sums are 22-bit signed and never overflow, even for full-scale input.
- R6: The decided bit is 1 when the one-path sum minus the zero-path sum is greater than or equal to zero, and 0 otherwise. Equal sums give 1.
- R7: Samples at index 64 and beyond do not change the decision. They are ignored until the next boundary.
- R8: `bit_vld_o` is a single-cycle pulse. It appears after edge P+2 of each boundary, for the symbol that the boundary closes. The first boundary after reset gives no pulse.
- R9: `bit_o` changes only together with a `bit_vld_o` pulse and holds its value in between.
- R10: A symbol with fewer than 64 samples is decided from the sums over only the samples it received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock; one ADC word per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| bsync_i | input | 1 | Bit-sync square wave; its rising edge starts a symbol |
| adc_i | input | 8 | Unsigned ADC sample, mid-scale 128 |
| bit_o | output | 1 | Last decided data bit |
| bit_vld_o | output | 1 | One-cycle strobe: `bit_o` has just been updated |

## Verification
The ports show a wrong index counter, a misaligned reference entry or a wrong accumulator value only as a wrong bit. That bit appears at the boundary that closes the affected symbol, so the bench compares every symbol's decision against sums it computes itself from the sample values. Random sample sweeps give sums that lie close to each other, so a single wrong product tends to flip the bit. Framing faults show up within one cycle of a boundary as a missing, extra or misplaced strobe. The bench checks every cycle for the strobe and for `bit_o` holding its value.

// File: rtl/cd_pkg.sv
package cd_pkg;

    parameter int SAMP_W  = 8;
    parameter int REF_W   = 8;
    parameter int SYM_LEN = 64;

    localparam int ADDR_W = $clog2(SYM_LEN);
    localparam int IDX_W  = ADDR_W + 1;
    localparam int PROD_W = SAMP_W + REF_W;
    localparam int ACC_W  = PROD_W + ADDR_W;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [REF_W-1:0]  ref_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic [ADDR_W-1:0]        addr_t;

    typedef enum logic {
        PATH_ZERO = 1'b0,
        PATH_ONE  = 1'b1
    } path_e;

    typedef struct packed {
        acc_t zero;
        acc_t one;
    } corr_pair_t;

    // Triangle approximation of one chirp cycle, swept by a quadratic phase.
    function automatic ref_t ref_sample(input path_e path, input int idx);
        int   sq;
        int   ph_i;
        logic [7:0] ph;
        ref_t val;
        sq = (idx * idx) >> 5;
        if (path == PATH_ONE) ph_i = 6 * idx - sq;
        else                  ph_i = 2 * idx + sq;
        ph = 8'(ph_i);
        if (ph[7]) val = REF_W'(191 - int'(ph));
        else       val = REF_W'(int'(ph) - 64);
        return val;
    endfunction

    // Offset-binary to two's complement: flip the top bit.
    function automatic samp_t center(input logic [SAMP_W-1:0] raw);
        return samp_t'({~raw[SAMP_W-1], raw[SAMP_W-2:0]});
    endfunction

endpackage

// File: rtl/cd_bsync_edge.sv
module cd_bsync_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bsync_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= bsync_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/cd_ref_table.sv
module cd_ref_table
    import cd_pkg::*;
#(
    parameter path_e PATH = PATH_ZERO
) (
    input  addr_t addr_i,
    output ref_t  ref_o
);
    ref_t tab [SYM_LEN];

    for (genvar g = 0; g < SYM_LEN; g++) begin : g_tab
        assign tab[g] = ref_sample(PATH, g);
    end

    assign ref_o = tab[addr_i];
endmodule

// File: rtl/cd_mac_path.sv
module cd_mac_path
    import cd_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  restart_i,
    input  logic  en_i,
    input  samp_t samp_i,
    input  ref_t  ref_i,
    output acc_t  acc_o
);
    prod_t prod;
    acc_t  prod_ext;
    acc_t  acc_q;

    assign prod     = samp_i * ref_i;
    assign prod_ext = acc_t'(prod);

    always_ff @(posedge clk_i) begin
        if (rst_i)          acc_q <= '0;
        else if (restart_i) acc_q <= prod_ext;
        else if (en_i)      acc_q <= acc_q + prod_ext;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/chirp_corr_demod.sv
module chirp_corr_demod
    import cd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bsync_i,
    input  logic [SAMP_W-1:0] adc_i,
    output logic              bit_o,
    output logic              bit_vld_o
);
    logic       sym_start;
    idx_t       idx_q;
    logic       armed_q;
    logic       in_window;
    addr_t      addr;
    samp_t      samp_c;
    acc_t       acc_arr [2];
    acc_t       acc_zero;
    acc_t       acc_one;
    corr_pair_t corr;
    logic signed [ACC_W:0] diff;

    cd_bsync_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .bsync_i(bsync_i),
        .rise_o (sym_start)
    );

    assign in_window = (idx_q < idx_t'(SYM_LEN));
    assign addr      = sym_start ? '0 : idx_q[ADDR_W-1:0];
    assign samp_c    = center(adc_i);

    for (genvar p = 0; p < 2; p++) begin : g_path
        ref_t ref_v;

        cd_ref_table #(.PATH(path_e'(p))) u_ref (
            .addr_i(addr),
            .ref_o (ref_v)
        );

        cd_mac_path u_mac (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .restart_i(sym_start),
            .en_i     (in_window),
            .samp_i   (samp_c),
            .ref_i    (ref_v),
            .acc_o    (acc_arr[p])
        );
    end

    assign acc_zero  = acc_arr[PATH_ZERO];
    assign acc_one   = acc_arr[PATH_ONE];
    assign corr.zero = acc_zero;
    assign corr.one  = acc_one;
    assign diff      = {corr.one[ACC_W-1], corr.one} - {corr.zero[ACC_W-1], corr.zero};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_q     <= idx_t'(SYM_LEN);
            armed_q   <= 1'b0;
            bit_o     <= 1'b0;
            bit_vld_o <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            if (sym_start) begin
                idx_q   <= idx_t'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    bit_o     <= ~diff[ACC_W];
                    bit_vld_o <= 1'b1;
                end
            end else if (in_window) begin
                idx_q <= idx_q + idx_t'(1);
            end
        end
    end
endmodule

// File: rtl/cd_checker.sv
module cd_checker
    import cd_pkg::*;
(
    input logic clk_i,
    input logic rst_i,
    input logic sym_start_i,
    input idx_t idx_i,
    input acc_t acc0_i,
    input acc_t acc1_i,
    input logic bit_i,
    input logic vld_i
);
    localparam longint ACC_LIM = longint'(SYM_LEN) * (longint'(1) << (SAMP_W - 1))
                                 * (longint'(1) << (REF_W - 1));

    assert_index_restart_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        sym_start_i |=> (idx_i == idx_t'(1)));

    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (longint'(acc0_i) <= ACC_LIM) && (longint'(acc0_i) >= -ACC_LIM) &&
        (longint'(acc1_i) <= ACC_LIM) && (longint'(acc1_i) >= -ACC_LIM));

    assert_window_limit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_i <= idx_t'(SYM_LEN));

    assert_vld_after_edge_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |-> $past(sym_start_i));

    assert_vld_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |=> !vld_i);

    assert_bit_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |-> $stable(bit_i));
endmodule

bind chirp_corr_demod cd_checker u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sym_start_i(sym_start),
    .idx_i      (idx_q),
    .acc0_i     (acc_zero),
    .acc1_i     (acc_one),
    .bit_i      (bit_o),
    .vld_i      (bit_vld_o)
);

// File: tb/chirp_corr_demod_tb_top.sv
module chirp_corr_demod_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       bsync_i = 1'b0;
    logic [7:0] adc_i = 8'd128;
    logic       bit_o;
    logic       bit_vld_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit pend = 0;
    bit pend_bit = 0;
    bit last_bit = 0;
    string pend_req = "R6";
    logic [31:0] rs = 32'h1234_5678;
    int smp [0:127];

    always #2.5 clk_i = ~clk_i;

    chirp_corr_demod dut_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bsync_i  (bsync_i),
        .adc_i    (adc_i),
        .bit_o    (bit_o),
        .bit_vld_o(bit_vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tri_ref(input int one, input int j);
        int p;
        if (one != 0) p = (6 * j - (j * j) / 32) % 256;
        else          p = (2 * j + (j * j) / 32) % 256;
        return (p < 128) ? p - 64 : 191 - p;
    endfunction

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    task automatic rnd(output int v);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        v = int'(rs & 32'h7fff_ffff);
    endtask

    // mode 0: clean chirp (arg=bit) with amplitude amp and noise span nz plus offset
    // mode 1: random bytes; mode 2: constant arg
    task automatic fill(input int len, input int mode, input int arg,
                        input int amp, input int nz, input int offs);
        for (int j = 0; j < len; j++) begin
            int r;
            rnd(r);
            if (mode == 0)
                smp[j] = clamp8(128 + offs + (amp * tri_ref(arg, j % 64)) / 64 +
                                ((nz > 0) ? (r % (2 * nz + 1)) - nz : 0));
            else if (mode == 1)
                smp[j] = r % 256;
            else
                smp[j] = arg;
        end
    endtask

    // Drives one symbol of len samples from smp[], checks the strobe timing,
    // then queues the expected decision for the boundary that follows.
    task automatic run_symbol(input int len, input string req);
        longint s0 = 0;
        longint s1 = 0;
        int lim;
        for (int j = 0; j < len; j++) begin
            @(negedge clk_i);
            if (j == 1) begin
                chk(bit_vld_o == pend, "R8", int'(bit_vld_o), int'(pend));
                if (pend) begin
                    chk(bit_o == pend_bit, pend_req, int'(bit_o), int'(pend_bit));
                    last_bit = pend_bit;
                end
                pend = 0;
            end else begin
                chk(bit_vld_o == 1'b0, "R8", int'(bit_vld_o), 0);
                chk(bit_o == last_bit, "R9", int'(bit_o), int'(last_bit));
            end
            adc_i   = 8'(smp[j]);
            bsync_i = (j < 2) || (j >= len - 2);
        end
        lim = (len < 64) ? len : 64;
        for (int j = 0; j < lim; j++) begin
            s0 += longint'(smp[j] - 128) * tri_ref(0, j);
            s1 += longint'(smp[j] - 128) * tri_ref(1, j);
        end
        pend     = 1;
        pend_bit = (s1 - s0 >= 0);
        pend_req = req;
    endtask

    initial begin
        int bits5 [5] = '{1, 1, 1, 0, 1};
        // reset state (R1)
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        chk(bit_vld_o == 1'b0, "R1", int'(bit_vld_o), 0);
        chk(bit_o == 1'b0, "R1", int'(bit_o), 0);
        rst_i = 1'b0;
        // idle samples before any boundary are ignored (R1)
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_i);
            adc_i = 8'd255;
            chk(bit_vld_o == 1'b0, "R1", int'(bit_vld_o), 0);
            chk(bit_o == 1'b0, "R1", int'(bit_o), 0);
        end
        // prime the first boundary: no strobe expected for it (R8)
        for (int k = 0; k < 2; k++) begin
            @(negedge clk_i);
            bsync_i = 1'b1;
            adc_i = 8'd128;
        end
        // alternating clean chirps (R2, R4, R6)
        for (int k = 0; k < 4; k++) begin
            fill(64, 0, (k + 1) % 2, 100, 0, 0);
            run_symbol(64, "R2");
        end
        foreach (bits5[k]) begin
            fill(64, 0, bits5[k], 90, 0, 0);
            run_symbol(64, "R4");
        end
        // noisy chirps with DC shift (R3)
        for (int k = 0; k < 16; k++) begin
            fill(64, 0, k % 2, 60 + k, 20, (k % 5) * 6 - 12);
            run_symbol(64, "R3");
        end
        // random sweep (R5)
        for (int k = 0; k < 200; k++) begin
            fill(64, 1, 0, 0, 0, 0);
            run_symbol(64, "R5");
        end
        // full-scale constants (R5) and exact tie (R6)
        fill(64, 2, 255, 0, 0, 0); run_symbol(64, "R5");
        fill(64, 2, 0, 0, 0, 0);   run_symbol(64, "R5");
        fill(64, 2, 128, 0, 0, 0); run_symbol(64, "R6");
        // long symbols: samples past index 63 must not count (R7)
        for (int k = 0; k < 4; k++) begin
            fill(64, 0, k % 2, 25, 0, 0);
            for (int j = 64; j < 96; j++)
                smp[j] = clamp8(128 + (127 * tri_ref((k + 1) % 2, j - 64)) / 64);
            run_symbol(96, "R7");
        end
        // short symbols (R10)
        for (int k = 0; k < 12; k++) begin
            if (k < 6) fill(20 + k * 5, 1, 0, 0, 0, 0);
            else       fill(20 + k * 5, 0, k % 2, 80, 10, 0);
            run_symbol(20 + k * 5, "R10");
        end
        // closing boundary for the last symbol
        fill(8, 2, 128, 0, 0, 0);
        run_symbol(8, "R8");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule